// File: doc/BRIEF.md
# Clock Channel Divider With Phase Offset and Group Sync

This block produces one output clock from a source clock by an integer ratio between 1 and 1024. A single 24-bit configuration word sets the ratio, a start offset of up to 63 source cycles, output inversion, power-down and whether the channel takes part in group synchronization. The word also carries a 4-bit driver-mode field and a low-power flag. The divider does not act on these two fields and passes them straight to its outputs for the analog driver.

Several channels driven by the same source and the same sync line come out phase-aligned. While the sync line is high, every channel that takes part holds its divided output low and reloads its counter. When the line falls, all of them restart on the same source edge. Each channel then waits its own offset before its first high phase. A channel with its ignore flag set keeps running through a sync.

Top module: `clk_chan_div`

## Requirements
- R1: The ratio is N = cfg_word[17:8] + 1. The undivided (raw) output repeats with period N source cycles. It is high for floor(N/2) cycles and then low for the rest. The first high phase begins on the first rising source edge that sees the divider released from sync or reset, plus the offset.
- R2: For odd N, the high phase is exactly one source cycle shorter than the low phase. For even N, the two phases are equal.
- R3: The offset P = cfg_word[23:18] (0 to 63) delays the first high phase by P source cycles after release. The raw output stays low during those cycles.
- R4: When cfg_word[7] is 1, clk_out is the inverse of the raw output. This includes the held and delay periods, where clk_out is 1.
- R5: When cfg_word[5] is 1, clk_out is 0 regardless of inversion. The counter keeps running, so clearing the bit brings back the same pattern without a re-sync.
- R6: While sync_req is high on a rising edge and cfg_word[6] is 0, the raw output is held low and the counter and offset are reloaded. The edge on which sync_req is first seen low starts the pattern of R1 and R3.
- R7: When cfg_word[6] is 1, sync_req has no effect on clk_out.
- R8: With N = 1, after the offset the raw output equals the source clock, so clk_out equals the source clock, or its inverse when cfg_word[7] is set.
- R9: drv_mode equals cfg_word[3:0] and low_pwr equals cfg_word[4], unchanged.
- R10: rst_n is synchronous and active low. During reset the raw output is low. Releasing reset starts the pattern in the same way as releasing sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock, divided and also used to time the divider |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_word | input | 24 | Channel configuration word |
| sync_req | input | 1 | Group sync: hold while high, restart when it falls |
| clk_out | output | 1 | Divided, offset, optionally inverted clock |
| drv_mode | output | 4 | Driver-mode field, passed through |
| low_pwr | output | 1 | Low-power flag, passed through |

## Verification
The bench compares every source cycle, in both clock phases, against a pattern it builds from N, P and the inversion flag. A design that swapped the high and low phase lengths for odd ratios, or was off by one in its offset count, would show its first rising edge or its duty cycle in the wrong cycle. The cases it targets are: the largest ratio with a non-zero offset; the largest offset; ratio 1 with and without offset and inversion; a sync arriving in the middle of a running pattern; an ignoring channel pulsed with sync while running; and power-down combined with inversion. Each has a typical failure. A power-down that merely gated the counter would resume out of phase. A design that applied inversion after the power-down gate would drive 1 while powered down. A design that ignored the ignore flag would restart its pattern when the sync pulse arrives.

// File: rtl/ccd_pkg.sv
`timescale 1ns/1ps
// ccd_pkg: field widths and the packed layout of the channel configuration word.
// Assumes the word is ordered MSB first: offset, ratio-1, flags, driver mode.
package ccd_pkg;
    localparam int MODE_W = 4;
    localparam int DIV_W  = 10;
    localparam int PH_W   = 6;
    localparam int FLAG_W = 4;
    localparam int CFG_W  = PH_W + DIV_W + FLAG_W + MODE_W;

    typedef struct packed {
        logic [PH_W-1:0]   phase;
        logic [DIV_W-1:0]  ratio_m1;
        logic              invert;
        logic              no_sync;
        logic              pwr_off;
        logic              low_pwr;
        logic [MODE_W-1:0] drv_mode;
    } chan_cfg_t;
endpackage

// File: rtl/ccd_cfg_decode.sv
`timescale 1ns/1ps
// ccd_cfg_decode: splits the configuration word into fields and derives the
// high-phase length floor(N/2) and the ratio-one flag. Purely combinational.
module ccd_cfg_decode
    import ccd_pkg::*;
(
    input  logic [CFG_W-1:0] cfg_word,
    output chan_cfg_t        cfg,
    output logic [DIV_W-1:0] hi_len,
    output logic             unity
);
    logic [DIV_W:0] ratio_full;

    // Unpack the word and derive N, floor(N/2) and the N==1 flag.
    always_comb begin
        cfg        = chan_cfg_t'(cfg_word);
        ratio_full = {1'b0, cfg.ratio_m1} + 1'b1;
        hi_len     = ratio_full[DIV_W:1];
        unity      = (cfg.ratio_m1 == '0);
    end
endmodule

// File: rtl/ccd_phase_gate.sv
`timescale 1ns/1ps
// ccd_phase_gate: owns the hold/restart condition and the start-offset
// countdown. Restart is reset or a sync the channel does not ignore; after
// restart the countdown runs P cycles, then 'run' rises and 'advance' lets
// the counter step. Assumes rst_n is synchronous to clk.
module ccd_phase_gate
    import ccd_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sync_req,
    input  logic            no_sync,
    input  logic [PH_W-1:0] phase,
    output logic            restart,
    output logic            advance,
    output logic            run,
    output logic [PH_W-1:0] dly
);
    // Hold condition: reset, or a sync the channel takes part in.
    always_comb restart = !rst_n || (sync_req && !no_sync);

    // The counter may step only once the offset has run out.
    always_comb advance = !restart && (dly == '0);

    // Reload the offset on restart, count it down, then mark the channel running.
    always_ff @(posedge clk) begin
        if (restart) begin
            dly <= phase;
            run <= 1'b0;
        end else if (dly != '0) begin
            dly <= dly - 1'b1;
        end else begin
            run <= 1'b1;
        end
    end
endmodule

// File: rtl/ccd_div_counter.sv
`timescale 1ns/1ps
// ccd_div_counter: modulo-N counter that makes the raw divided level, high
// for the first floor(N/2) counts of each period. Held at zero while the
// phase gate withholds 'advance'.
module ccd_div_counter
    import ccd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             advance,
    input  logic [DIV_W-1:0] ratio_m1,
    input  logic [DIV_W-1:0] hi_len,
    output logic [DIV_W-1:0] cnt,
    output logic             div_q
);
    // Step the period counter and register the raw level for the current count.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt   <= '0;
            div_q <= 1'b0;
        end else if (advance) begin
            div_q <= (cnt < hi_len);
            cnt   <= (cnt >= ratio_m1) ? '0 : cnt + 1'b1;
        end else begin
            div_q <= 1'b0;
        end
    end
endmodule

// File: rtl/ccd_out_stage.sv
`timescale 1ns/1ps
// ccd_out_stage: picks the raw level (the source clock itself for N==1,
// otherwise the counter level), applies inversion, and forces 0 when the
// channel is powered down. Combinational; glitch behaviour is not managed.
module ccd_out_stage (
    input  logic src_clk,
    input  logic unity,
    input  logic run,
    input  logic div_q,
    input  logic invert,
    input  logic pwr_off,
    output logic clk_out
);
    logic raw;

    // Select the raw level, then invert it or force it off.
    always_comb begin
        raw     = unity ? (run & src_clk) : div_q;
        clk_out = pwr_off ? 1'b0 : (raw ^ invert);
    end
endmodule

// File: rtl/clk_chan_div.sv
`timescale 1ns/1ps
// clk_chan_div: one output-clock divider channel, with a ratio of 1..1024, a
// start offset of 0..63 cycles, inversion, power-down and group sync. The
// source clock also clocks the divider. The driver-mode and low-power
// fields are only passed through.
module clk_chan_div
    import ccd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_W-1:0]  cfg_word,
    input  logic              sync_req,
    output logic              clk_out,
    output logic [MODE_W-1:0] drv_mode,
    output logic              low_pwr
);
    chan_cfg_t        cfg_s;
    logic [DIV_W-1:0] hi_len_w;
    logic             unity_w;
    logic             restart_w;
    logic             advance_w;
    logic             run_w;
    logic [PH_W-1:0]  dly_w;
    logic [DIV_W-1:0] cnt_w;
    logic             div_q_w;

    ccd_cfg_decode u_decode (
        .cfg_word (cfg_word),
        .cfg      (cfg_s),
        .hi_len   (hi_len_w),
        .unity    (unity_w)
    );

    ccd_phase_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_req (sync_req),
        .no_sync  (cfg_s.no_sync),
        .phase    (cfg_s.phase),
        .restart  (restart_w),
        .advance  (advance_w),
        .run      (run_w),
        .dly      (dly_w)
    );

    ccd_div_counter u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart_w),
        .advance  (advance_w),
        .ratio_m1 (cfg_s.ratio_m1),
        .hi_len   (hi_len_w),
        .cnt      (cnt_w),
        .div_q    (div_q_w)
    );

    ccd_out_stage u_out (
        .src_clk  (clk),
        .unity    (unity_w),
        .run      (run_w),
        .div_q    (div_q_w),
        .invert   (cfg_s.invert),
        .pwr_off  (cfg_s.pwr_off),
        .clk_out  (clk_out)
    );

    // Driver fields go straight out untouched.
    always_comb begin
        drv_mode = cfg_s.drv_mode;
        low_pwr  = cfg_s.low_pwr;
    end
endmodule

// File: rtl/ccd_checker.sv
`timescale 1ns/1ps
// ccd_checker: temporal properties of the divider's internal pipeline,
// bound into clk_chan_div. Assumes the configuration changes only while the
// channel is held, or leaves the ratio unchanged.
module ccd_checker
    import ccd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_req,
    input  logic             no_sync,
    input  logic [DIV_W-1:0] ratio_m1,
    input  logic [PH_W-1:0]  phase,
    input  logic [PH_W-1:0]  dly,
    input  logic             run,
    input  logic             div_q,
    input  logic [DIV_W-1:0] cnt
);
    logic hold_now;
    always_comb hold_now = sync_req && !no_sync;

    // R6: a sync that is not ignored leaves the channel silent on the next cycle.
    assert_sync_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hold_now |=> (!div_q && !run));

    // R3: a hold reloads the offset countdown with the programmed offset.
    assert_offset_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hold_now |=> (dly == $past(phase)));

    // R3: outside a hold, a non-zero offset counts down by one per cycle.
    assert_offset_countdown_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_now && dly != '0) |=> (dly == $past(dly) - 1'b1));

    // R1: with a steady ratio, a high phase begins only at the start of a period.
    assert_rise_at_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(div_q) && $stable(ratio_m1)) |-> (cnt == DIV_W'(1)));

    // R8: at ratio one the counter level never goes high.
    assert_unity_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ratio_m1) == '0) |-> !div_q);
endmodule

bind clk_chan_div ccd_checker u_ccd_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_req (sync_req),
    .no_sync  (cfg_s.no_sync),
    .ratio_m1 (cfg_s.ratio_m1),
    .phase    (cfg_s.phase),
    .dly      (dly_w),
    .run      (run_w),
    .div_q    (div_q_w),
    .cnt      (cnt_w)
);

// File: tb/test_clk_chan_div.sv
`timescale 1ns/1ps
// test_clk_chan_div: table-driven pattern checks, then directed tests for
// reset, the ignore flag and power-down. Inputs change 5 ns or 15 ns after
// a rising edge; clk_out is sampled at +5 ns (clock high) and +15 ns (clock low).
module test_clk_chan_div;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] cfg_word = '0;
    logic        sync_req = 1'b0;
    logic        clk_out;
    logic [3:0]  drv_mode;
    logic        low_pwr;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;   // 50 MHz

    clk_chan_div i_clk_chan_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_word (cfg_word),
        .sync_req (sync_req),
        .clk_out  (clk_out),
        .drv_mode (drv_mode),
        .low_pwr  (low_pwr)
    );

    typedef struct packed {
        logic [10:0] n;
        logic [5:0]  p;
        logic        inv;
        logic [9:0]  hi;
    } vec_t;

    // ratio, offset, invert, expected high-phase length
    localparam vec_t VECS [0:8] = '{
        '{n: 11'd1,    p: 6'd0,  inv: 1'b0, hi: 10'd0},
        '{n: 11'd1,    p: 6'd3,  inv: 1'b1, hi: 10'd0},
        '{n: 11'd2,    p: 6'd0,  inv: 1'b0, hi: 10'd1},
        '{n: 11'd3,    p: 6'd2,  inv: 1'b0, hi: 10'd1},
        '{n: 11'd4,    p: 6'd5,  inv: 1'b1, hi: 10'd2},
        '{n: 11'd5,    p: 6'd0,  inv: 1'b0, hi: 10'd2},
        '{n: 11'd6,    p: 6'd0,  inv: 1'b1, hi: 10'd3},
        '{n: 11'd7,    p: 6'd63, inv: 1'b0, hi: 10'd3},
        '{n: 11'd1024, p: 6'd1,  inv: 1'b0, hi: 10'd512}
    };

    function automatic logic [23:0] mk_cfg(int n, int p, logic inv, logic ign,
                                           logic pd, logic lp, logic [3:0] mode);
        logic [9:0] rm1 = 10'(n - 1);
        logic [5:0] ph  = 6'(p);
        return {ph, rm1, inv, ign, pd, lp, mode};
    endfunction

    function automatic logic exp_out(int k, int n, int p, logic inv, int hi,
                                     logic pd, logic clk_high);
        logic raw;
        if (pd) return 1'b0;
        if (k < p)       raw = 1'b0;
        else if (n == 1) raw = clk_high;
        else             raw = ((k - p) % n) < hi;
        return raw ^ inv;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One source cycle k after release: wait for its edge, check both clock phases.
    task automatic sample_cycle(int k, int n, int p, logic inv, int hi, logic pd, string req);
        @(posedge clk);
        #5;
        chk(req, {31'b0, clk_out}, {31'b0, exp_out(k, n, p, inv, hi, pd, 1'b1)});
        #10;
        chk(req, {31'b0, clk_out}, {31'b0, exp_out(k, n, p, inv, hi, pd, 1'b0)});
    endtask

    // Sync the channel into a new setting, check the hold, then two full periods.
    task automatic run_vec(vec_t v);
        int n  = int'(v.n);
        int p  = int'(v.p);
        int hi = int'(v.hi);
        string tag;
        @(posedge clk);
        #5;
        cfg_word = mk_cfg(n, p, v.inv, 1'b0, 1'b0, 1'b0, 4'h0);
        sync_req = 1'b1;
        @(posedge clk);
        #5;
        chk("R6 hold", {31'b0, clk_out}, {31'b0, v.inv});
        sync_req = 1'b0;
        for (int k = 0; k < p + 2 * n; k++) begin
            if (k < p)          tag = "R3";
            else if (n == 1)    tag = "R8";
            else if (v.inv)     tag = "R4";
            else if (n % 2 == 1) tag = "R2";
            else                tag = "R1";
            sample_cycle(k, n, p, v.inv, hi, 1'b0, tag);
        end
    endtask

    initial begin
        // Reset: held output, pass-through fields, then release like a sync (R10, R9).
        cfg_word = mk_cfg(4, 2, 1'b1, 1'b0, 1'b0, 1'b1, 4'hA);
        repeat (2) @(posedge clk);
        #5;
        chk("R10 reset inverted", {31'b0, clk_out}, 32'd1);
        chk("R9 drv_mode", {28'b0, drv_mode}, 32'hA);
        chk("R9 low_pwr", {31'b0, low_pwr}, 32'd1);
        cfg_word = mk_cfg(4, 2, 1'b0, 1'b0, 1'b0, 1'b0, 4'h5);
        @(posedge clk);
        #5;
        chk("R10 reset low", {31'b0, clk_out}, 32'd0);
        chk("R9 drv_mode", {28'b0, drv_mode}, 32'h5);
        chk("R9 low_pwr", {31'b0, low_pwr}, 32'd0);
        rst_n = 1'b1;
        for (int k = 0; k < 12; k++) sample_cycle(k, 4, 2, 1'b0, 2, 1'b0, "R10");

        // Table of ratio / offset / inversion settings (R1..R4, R6, R8).
        for (int i = 0; i < 9; i++) run_vec(VECS[i]);

        // Ignore flag: a sync pulse mid-run leaves the pattern alone (R7).
        @(posedge clk);
        #5;
        rst_n = 1'b0;
        cfg_word = mk_cfg(4, 0, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0);
        @(posedge clk);
        #5;
        rst_n = 1'b1;
        for (int k = 0; k < 20; k++) begin
            sample_cycle(k, 4, 0, 1'b0, 2, 1'b0, "R7");
            if (k == 5) sync_req = 1'b1;
            if (k == 8) sync_req = 1'b0;
        end

        // Power-down with inversion forces 0; clearing it resumes in step (R5).
        @(posedge clk);
        #5;
        cfg_word = mk_cfg(3, 0, 1'b1, 1'b0, 1'b1, 1'b0, 4'h0);
        sync_req = 1'b1;
        @(posedge clk);
        #5;
        chk("R5 held off", {31'b0, clk_out}, 32'd0);
        sync_req = 1'b0;
        for (int k = 0; k < 8; k++) sample_cycle(k, 3, 0, 1'b1, 1, 1'b1, "R5");
        cfg_word = mk_cfg(3, 0, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0);
        for (int k = 8; k < 14; k++) sample_cycle(k, 3, 0, 1'b1, 1, 1'b0, "R5");

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #2000000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule